// File: doc/BRIEF.md
# Double-Pumped Two-Port Memory

This block turns one single-ported storage array into a memory with two independent logical ports. The array and its small scheduler run on a clock at twice the core rate. The two clocks come from outside the block and have aligned rising edges. At each core rising edge the block captures a request from each logical port. During the first half of the following core cycle the array serves port A. During the second half it serves port B. Both read results are then registered into the core domain at the next core edge.

Seen from the core clock domain, the block behaves like an ideal dual-ported memory. It accepts one request per port in every core cycle, never stalls, and gives every read a fixed latency of one core cycle. The phase order is fixed, and this defines the result of same-address accesses within one cycle. Port A always acts first. A read on port B therefore sees a write made by port A in the same cycle. A read on port A never sees a write made by port B in the same cycle.

Reset is asynchronous and active low. It must be released shortly after a core rising edge, so that the first fast edge that follows falls in the middle of a core cycle.

Top module: `double_pumped_ram`

## Requirements
- R1: While reset is asserted, and after it is released, both read outputs are zero until a read completes. The phase register starts in the port A phase.
- R2: A read request captured at core edge k returns its data on the port's read output just after core edge k+1. The data reflects every write accepted in earlier core cycles.
- R3: Both ports may read in the same core cycle, at different addresses or at the same address. Each gets its own correct data, with no stall.
- R4: If port A writes an address and port B reads that address in the same core cycle, port B returns the value port A just wrote.
- R5: If port B writes an address and port A reads that address in the same core cycle, port A returns the value held before that cycle. Later reads see port B's value.
- R6: If both ports write the same address in one core cycle, the stored value afterwards is port B's write data.
- R7: A port's read output keeps its previous value in any cycle where that port does not read: either its enable is 0, or it is writing (write flag 1).
- R8: A port whose enable is 0 does not change the array, whatever its write flag, address and write data are.
- R9: The phase register changes on every fast clock edge. At every core rising edge it has just finished the port B phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| clk2x | input | 1 | Fast clock at twice the core rate, rising edges aligned with clk |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_en | input | 1 | Port A request enable |
| a_we | input | 1 | Port A write flag (1 = write, 0 = read) |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A registered read data |
| b_en | input | 1 | Port B request enable |
| b_we | input | 1 | Port B write flag (1 = write, 0 = read) |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B registered read data |

## Verification
The hardest case to reach from the ports is a collision inside one core cycle. Both ports target the same word, and the answer depends only on the order of the two fast phases. The stimulus first fills the whole array through both ports at once. It then issues directed cycles in which A writes while B reads, B writes while A reads, and both write, each at the same address, and it follows each with a plain read to expose what stayed in the array. After that comes a long pseudo-random mix over a small address window, so that same-address pairs keep occurring. A reference model applies A before B and predicts every result.

// File: rtl/dpm_pkg.sv
`timescale 1ns/1ps
package dpm_pkg;

  // Fast phase within one core cycle: port A first, port B second
  typedef enum logic {
    PH_A = 1'b0,
    PH_B = 1'b1
  } phase_e;

  function automatic logic is_read(input logic en, input logic we);
    return en & ~we;
  endfunction

  function automatic logic is_write(input logic en, input logic we);
    return en & we;
  endfunction

  function automatic phase_e next_phase(input phase_e p);
    return (p == PH_A) ? PH_B : PH_A;
  endfunction

  // Index of the logical port that owns the physical port in a phase
  function automatic int unsigned owner(input phase_e p);
    return (p == PH_A) ? 0 : 1;
  endfunction

endpackage

// File: rtl/dpm_req_capture.sv
`timescale 1ns/1ps
// Core-domain request register for one logical port
module dpm_req_capture #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_en,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              cap_en,
  output logic              cap_we,
  output logic [ADDR_W-1:0] cap_addr,
  output logic [DATA_W-1:0] cap_wdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_en    <= 1'b0;
      cap_we    <= 1'b0;
      cap_addr  <= '0;
      cap_wdata <= '0;
    end else begin
      cap_en    <= req_en;
      cap_we    <= req_we;
      cap_addr  <= req_addr;
      cap_wdata <= req_wdata;
    end
  end

endmodule

// File: rtl/dpm_phase_ctrl.sv
`timescale 1ns/1ps
// Fast-domain phase toggle: selects which captured request owns the array
module dpm_phase_ctrl
  import dpm_pkg::*;
(
  input  logic   clk2x,
  input  logic   rst_n,
  output phase_e phase
);

  always_ff @(posedge clk2x or negedge rst_n) begin
    if (!rst_n) phase <= PH_A;
    else        phase <= next_phase(phase);
  end

  AST_PHASE_TOGGLES: assert property (@(posedge clk2x) disable iff (!rst_n)
    1'b1 |=> (phase != $past(phase))); // R9

endmodule

// File: rtl/dpm_port_sched.sv
`timescale 1ns/1ps
// Steers the single physical port between the two captured requests and
// holds the port A read result until the core edge.
module dpm_port_sched
  import dpm_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int NPORT  = 2
) (
  input  logic                         clk2x,
  input  logic                         rst_n,
  input  phase_e                       phase,
  input  logic [NPORT-1:0]             cap_en,
  input  logic [NPORT-1:0]             cap_we,
  input  logic [NPORT-1:0][ADDR_W-1:0] cap_addr,
  input  logic [NPORT-1:0][DATA_W-1:0] cap_wdata,
  input  logic [DATA_W-1:0]            arr_rdata,
  output logic                         arr_we,
  output logic [ADDR_W-1:0]            arr_addr,
  output logic [DATA_W-1:0]            arr_wdata,
  output logic [DATA_W-1:0]            a_hold,
  output logic [DATA_W-1:0]            b_live
);

  int unsigned sel;
  logic        a_read_now;

  always_comb begin
    sel       = owner(phase);
    arr_addr  = cap_addr[sel];
    arr_wdata = cap_wdata[sel];
    arr_we    = is_write(cap_en[sel], cap_we[sel]);
  end

  assign a_read_now = (phase == PH_A) && is_read(cap_en[0], cap_we[0]);

  // Port A result sampled at the end of its phase
  always_ff @(posedge clk2x or negedge rst_n) begin
    if (!rst_n)          a_hold <= '0;
    else if (a_read_now) a_hold <= arr_rdata;
  end

  // Port B result is taken straight from the array at the core edge
  assign b_live = arr_rdata;

endmodule

// File: rtl/dpm_array.sv
`timescale 1ns/1ps
// Single-ported storage: one address, synchronous write, combinational read
module dpm_array #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk2x,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk2x) begin
    if (we) cells[addr] <= wdata;
  end

  assign rdata = cells[addr];

endmodule

// File: rtl/dpm_read_stage.sv
`timescale 1ns/1ps
// Core-domain read output register for one logical port
module dpm_read_stage #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    dout <= '0;
    else if (load) dout <= din;
  end

endmodule

// File: rtl/double_pumped_ram.sv
`timescale 1ns/1ps
module double_pumped_ram
  import dpm_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              clk2x,
  input  logic              rst_n,
  input  logic              a_en,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic              b_en,
  input  logic              b_we,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata
);

  localparam int NPORT = 2;

  logic [NPORT-1:0]             in_en, in_we;
  logic [NPORT-1:0][ADDR_W-1:0] in_addr;
  logic [NPORT-1:0][DATA_W-1:0] in_wdata;

  logic [NPORT-1:0]             cap_en, cap_we;
  logic [NPORT-1:0][ADDR_W-1:0] cap_addr;
  logic [NPORT-1:0][DATA_W-1:0] cap_wdata;

  logic [NPORT-1:0][DATA_W-1:0] rd_src;
  logic [NPORT-1:0][DATA_W-1:0] rd_q;
  logic [NPORT-1:0]             rd_load;

  phase_e             phase;
  logic               arr_we;
  logic [ADDR_W-1:0]  arr_addr;
  logic [DATA_W-1:0]  arr_wdata, arr_rdata;
  logic [DATA_W-1:0]  a_hold, b_live;

  // Named events for the assertions
  logic fwd_a_to_b;

  assign in_en    = {b_en, a_en};
  assign in_we    = {b_we, a_we};
  assign in_addr  = {b_addr, a_addr};
  assign in_wdata = {b_wdata, a_wdata};

  assign rd_src = {b_live, a_hold};

  genvar p;
  generate
    for (p = 0; p < NPORT; p++) begin : g_port
      dpm_req_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_en    (in_en[p]),
        .req_we    (in_we[p]),
        .req_addr  (in_addr[p]),
        .req_wdata (in_wdata[p]),
        .cap_en    (cap_en[p]),
        .cap_we    (cap_we[p]),
        .cap_addr  (cap_addr[p]),
        .cap_wdata (cap_wdata[p])
      );

      assign rd_load[p] = is_read(cap_en[p], cap_we[p]);

      dpm_read_stage #(.DATA_W(DATA_W)) u_rd (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (rd_load[p]),
        .din   (rd_src[p]),
        .dout  (rd_q[p])
      );
    end
  endgenerate

  dpm_phase_ctrl u_phase (
    .clk2x (clk2x),
    .rst_n (rst_n),
    .phase (phase)
  );

  dpm_port_sched #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NPORT(NPORT)) u_sched (
    .clk2x     (clk2x),
    .rst_n     (rst_n),
    .phase     (phase),
    .cap_en    (cap_en),
    .cap_we    (cap_we),
    .cap_addr  (cap_addr),
    .cap_wdata (cap_wdata),
    .arr_rdata (arr_rdata),
    .arr_we    (arr_we),
    .arr_addr  (arr_addr),
    .arr_wdata (arr_wdata),
    .a_hold    (a_hold),
    .b_live    (b_live)
  );

  dpm_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk2x (clk2x),
    .we    (arr_we),
    .addr  (arr_addr),
    .wdata (arr_wdata),
    .rdata (arr_rdata)
  );

  assign a_rdata = rd_q[0];
  assign b_rdata = rd_q[1];

  assign fwd_a_to_b = is_write(cap_en[0], cap_we[0]) &&
                      is_read(cap_en[1], cap_we[1]) &&
                      (cap_addr[0] == cap_addr[1]);

  AST_CORE_EDGE_AFTER_B: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_B); // R9

  AST_A_WRITE_SEEN_BY_B: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_a_to_b |=> (b_rdata == $past(cap_wdata[0]))); // R4

  AST_A_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !is_read(cap_en[0], cap_we[0]) |=> $stable(a_rdata)); // R7

  AST_B_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !is_read(cap_en[1], cap_we[1]) |=> $stable(b_rdata)); // R7

  AST_RESET_OUTPUTS_ZERO: assert property (@(posedge clk)
    !rst_n |-> (a_rdata == '0 && b_rdata == '0)); // R1

endmodule

// File: tb/double_pumped_ram_tb_top.sv
`timescale 1ns/1ps
module double_pumped_ram_tb_top;

  localparam int AW = 6;
  localparam int DW = 16;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic clk2x = 1'b1;
  logic rst_n = 1'b0;

  logic          a_en = 0, a_we = 0, b_en = 0, b_we = 0;
  logic [AW-1:0] a_addr = '0, b_addr = '0;
  logic [DW-1:0] a_wdata = '0, b_wdata = '0;
  logic [DW-1:0] a_rdata, b_rdata;

  // 200 MHz core clock, 400 MHz fast clock, rising edges aligned
  always #2.5  clk   = ~clk;
  always #1.25 clk2x = ~clk2x;

  double_pumped_ram #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .clk2x(clk2x), .rst_n(rst_n),
    .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata)
  );

  typedef struct {
    int          due;
    int          port;
    logic [DW-1:0] exp;
    string       req;
  } item_t;

  item_t         sb_q[$];
  int            checks = 0;
  int            errors = 0;
  int            cyc = 0;
  logic [DW-1:0] model [DEPTH];
  logic [DW-1:0] exp_a = '0, exp_b = '0;
  logic [31:0]   lfsr = 32'h1ACE_B00C;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  // Driver: applies one core-cycle request pair and predicts the results
  task automatic drive(input logic ae, input logic awe, input logic [AW-1:0] aad, input logic [DW-1:0] awd,
                       input logic be, input logic bwe, input logic [AW-1:0] bad, input logic [DW-1:0] bwd,
                       input string req);
    item_t it;
    string ta, tb;
    @(negedge clk);
    a_en = ae; a_we = awe; a_addr = aad; a_wdata = awd;
    b_en = be; b_we = bwe; b_addr = bad; b_wdata = bwd;
    ta = "R7"; tb = "R7";
    // port A acts first
    if (ae && !awe) begin exp_a = model[aad]; ta = req; end
    if (ae && awe) model[aad] = awd;
    // then port B
    if (be && !bwe) begin exp_b = model[bad]; tb = req; end
    if (be && bwe) model[bad] = bwd;
    it.due = cyc + 2; it.port = 0; it.exp = exp_a; it.req = ta; sb_q.push_back(it);
    it.due = cyc + 2; it.port = 1; it.exp = exp_b; it.req = tb; sb_q.push_back(it);
  endtask

  task automatic idle();
    drive(0, 0, '0, '0, 0, 0, '0, '0, "R7");
  endtask

  // Monitor: compares results as they appear
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].due == cyc) begin
      item_t it;
      it = sb_q.pop_front();
      if (it.port == 0) check(it.req, a_rdata, it.exp, "port A read");
      else              check(it.req, b_rdata, it.exp, "port B read");
    end
  end

  initial begin : watchdog
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL R2 watchdog expired actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    check("R1", a_rdata, '0, "port A during reset");
    check("R1", b_rdata, '0, "port B during reset");
    @(posedge clk);
    #0.5 rst_n = 1'b1;
    @(negedge clk);
    check("R1", a_rdata, '0, "port A after reset");
    check("R1", b_rdata, '0, "port B after reset");

    // Fill the array through both ports at once
    for (int i = 0; i < DEPTH / 2; i++)
      drive(1, 1, AW'(i), DW'(16'h1000 + i), 1, 1, AW'(i + DEPTH / 2), DW'(16'h2000 + i), "R2");

    // R2: plain reads with latency of one core cycle
    drive(1, 0, 6'd3, '0, 0, 0, '0, '0, "R2");
    drive(0, 0, '0, '0, 1, 0, 6'd40, '0, "R2");
    // R3: parallel reads at different and same addresses
    drive(1, 0, 6'd10, '0, 1, 0, 6'd50, '0, "R3");
    drive(1, 0, 6'd21, '0, 1, 0, 6'd21, '0, "R3");
    // R4: A writes, B reads the same word in one cycle
    drive(1, 1, 6'd12, 16'hA4A4, 1, 0, 6'd12, '0, "R4");
    // R5: B writes, A reads the same word; A sees the old value, then the new one
    drive(1, 0, 6'd13, '0, 1, 1, 6'd13, 16'hB5B5, "R5");
    drive(1, 0, 6'd13, '0, 0, 0, '0, '0, "R5");
    // R6: both write the same word; B's value stays
    drive(1, 1, 6'd14, 16'h6A6A, 1, 1, 6'd14, 16'h6B6B, "R6");
    drive(1, 0, 6'd14, '0, 1, 0, 6'd14, '0, "R6");
    // R8: disabled ports with write flag set change nothing
    drive(0, 1, 6'd15, 16'hDEAD, 0, 1, 6'd16, 16'hBEEF, "R8");
    drive(1, 0, 6'd15, '0, 1, 0, 6'd16, '0, "R8");
    // R7: writing ports and idle ports keep their outputs
    drive(1, 1, 6'd17, 16'h7777, 1, 1, 6'd18, 16'h8888, "R7");
    idle();
    idle();

    // Mixed traffic over a narrow address window to provoke collisions
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      drive(lfsr[0], lfsr[1], AW'(lfsr[4:2]), lfsr[20:5],
            lfsr[21], lfsr[22], AW'(lfsr[25:23]), DW'({lfsr[31:26], lfsr[9:0]}), "R2");
    end

    repeat (4) idle();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule